// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a fast source clock. Two divider chains are built in, and a select bit chooses one at run time. The coarse chain halves the source twice and then divides by a power of two. The fine chain halves the source once and then divides by an 8-bit linear value. The output is a registered SCLK level with a 50% duty cycle. A one-cycle pulse marks every source cycle in which SCLK changes level, so a shift engine can use it to clock data.

The divider settings come from two 32-bit control words. The main word carries a 3-bit exponent. The extended word carries an 8-bit linear count and the path-select bit. The extended word also holds a separate delay field in its low half, which this block does not use. The settings are copied into a local hold register only while no transfer is running, so a write during a frame cannot change the clock in the middle of that frame. When the block is disabled or no transfer is active, SCLK rests at the programmed idle polarity and the divide counter is cleared.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `enh_ctrl[24]` = 0, the SCLK period is 4·2^N source cycles. N is `main_ctrl[18:16]` (0 to 7).
- R2: With `enh_ctrl[24]` = 1, the SCLK period is 2·(N+1) source cycles. N is `enh_ctrl[23:16]` (0 to 255).
- R3: On both paths, the high and the low phases of SCLK are each exactly half the period.
- R4: While `rst_n` is low at a clock edge, `sclk` and `sclk_tick` are 0 after that edge.
- R5: While `enable` or `xfer_active` is low, `sclk` equals `cpol` one cycle later and `sclk_tick` stays 0. When a transfer starts, the first SCLK change comes exactly one half-period after the first edge at which both inputs are high.
- R6: Changes to the divider fields or to the select bit while `xfer_active` is high do not affect the running clock. They take effect once `xfer_active` has been low for a clock edge.
- R7: Bits of `main_ctrl` other than 18:16, and bits 15:0 and 31:25 of `enh_ctrl`, have no effect on the clock.
- R8: `sclk_tick` is high for exactly the cycles in which `sclk` has just changed level, which gives two pulses per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable |
| xfer_active | input | 1 | High while a transfer is in progress |
| cpol | input | 1 | Idle level of SCLK |
| main_ctrl | input | 32 | Main control word; exponent in bits 18:16 |
| enh_ctrl | input | 32 | Extended control word; linear count in 23:16, path select in 24 |
| sclk | output | 1 | Serial clock level |
| sclk_tick | output | 1 | One-cycle pulse on each SCLK level change |

## Verification
A wrong divide count or a wrong path selection shows at the ports at the first SCLK toggle. At most one half-period after a transfer starts, the gap between level changes is off. A broken hold register only shows when settings change mid-frame, and it appears within a half-period of that write. A faulty idle or tick path shows one cycle after the transfer ends, or as a pulse that does not line up with a level change. The bench therefore measures every gap between toggles, rather than only the average rate.

// File: rtl/spiclk_pkg.sv
// Shared types for the serial clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package spiclk_pkg;
    // Divider chain selection, encoded as the select bit itself
    typedef enum logic {
        PATH_POW2 = 1'b0,
        PATH_LIN  = 1'b1
    } path_e;
endpackage

// File: rtl/spiclk_cfg_hold.sv
// Extracts the divider fields from the two control words and holds them.
// The hold register loads only while no transfer runs, so a frame always
// sees one constant setting.
// Assumes: the field positions are fixed by the register layout.
module spiclk_cfg_hold
    import spiclk_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int EXP_W   = 3,
    parameter int LIN_W   = 8,
    parameter int EXP_LSB = 16,
    parameter int LIN_LSB = 16,
    parameter int SEL_BIT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_active,
    input  logic [CTRL_W-1:0] main_ctrl,
    input  logic [CTRL_W-1:0] enh_ctrl,
    output logic [EXP_W-1:0]  exp_q,
    output logic [LIN_W-1:0]  lin_q,
    output path_e             path_q
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{main_ctrl, enh_ctrl};

    // Copy the fields into the hold register between transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            lin_q  <= '0;
            path_q <= PATH_POW2;
        end else if (!xfer_active) begin
            exp_q  <= main_ctrl[EXP_LSB +: EXP_W];
            lin_q  <= enh_ctrl[LIN_LSB +: LIN_W];
            path_q <= path_e'(enh_ctrl[SEL_BIT]);
        end
    end

    // R6: the held setting does not move across an edge where a transfer ran
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(xfer_active) |->
            $stable(exp_q) && $stable(lin_q) && $stable(path_q));
endmodule

// File: rtl/spiclk_term_calc.sv
// Turns the held setting into the terminal count of the half-period counter.
// Coarse chain: half-period = (LEG_PRE/2)*2^N. Fine chain: (LIN_PRE/2)*(N+1).
// Assumes: both prescales are even, and CNT_W holds the largest half-period minus one.
module spiclk_term_calc
    import spiclk_pkg::*;
#(
    parameter int EXP_W   = 3,
    parameter int LIN_W   = 8,
    parameter int LEG_PRE = 4,
    parameter int LIN_PRE = 2,
    parameter int CNT_W   = 8
) (
    input  logic [EXP_W-1:0] exp_q,
    input  logic [LIN_W-1:0] lin_q,
    input  path_e            path_q,
    output logic [CNT_W-1:0] term
);
    localparam int EXP_STEPS = 2 ** EXP_W;
    localparam int LEG_HALF  = LEG_PRE / 2;
    localparam int LIN_HALF  = LIN_PRE / 2;

    logic [CNT_W-1:0] leg_tab [EXP_STEPS];
    logic [CNT_W:0]   lin_half;
    logic [CNT_W:0]   lin_minus;

    // One constant terminal count per exponent value
    for (genvar i = 0; i < EXP_STEPS; i++) begin : g_leg
        assign leg_tab[i] = CNT_W'(LEG_HALF * (2 ** i) - 1);
    end

    // Linear half-period: the prescale half times (N + 1)
    always_comb begin
        lin_half  = (CNT_W+1)'(LIN_HALF) * ((CNT_W+1)'(lin_q) + (CNT_W+1)'(1));
        lin_minus = lin_half - (CNT_W+1)'(1);
    end

    // Path mux driven by the held select bit
    always_comb begin
        if (path_q == PATH_LIN) begin
            term = lin_minus[CNT_W-1:0];
        end else begin
            term = leg_tab[exp_q];
        end
    end

    logic unused_lin_msb;
    assign unused_lin_msb = lin_minus[CNT_W];
endmodule

// File: rtl/spiclk_edge_gen.sv
// Half-period counter and SCLK toggle register. It toggles SCLK, and pulses
// the tick, every term+1 cycles while running. Outside a run it parks SCLK at
// the idle level and clears the counter.
// Assumes: term stays constant while run is high.
module spiclk_edge_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle_lvl,
    input  logic [CNT_W-1:0] term,
    output logic             sclk,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    // Count half-periods and flip the clock level at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
            tick <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= idle_lvl;
            tick <= 1'b0;
        end else if (cnt == term) begin
            cnt  <= '0;
            sclk <= ~sclk;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

    // R5: an idle cycle leaves SCLK at the idle level
    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(run) |-> sclk == $past(idle_lvl));

    // R5: no tick follows an idle cycle
    p_no_tick_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

    // R8: every tick coincides with a level change
    p_tick_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tick |-> sclk != $past(sclk));

    // R3: the counter never passes the terminal count while running
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= term);
endmodule

// File: rtl/spi_sclk_gen.sv
// Top of the dual-path serial clock generator. It holds the divider setting
// between transfers, computes the half-period and drives SCLK and its tick.
// Assumes: the source clock is the only clock and the reset is synchronous.
module spi_sclk_gen
    import spiclk_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int EXP_W   = 3,
    parameter int LIN_W   = 8,
    parameter int LEG_PRE = 4,
    parameter int LIN_PRE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              xfer_active,
    input  logic              cpol,
    input  logic [CTRL_W-1:0] main_ctrl,
    input  logic [CTRL_W-1:0] enh_ctrl,
    output logic              sclk,
    output logic              sclk_tick
);
    localparam int EXP_STEPS = 2 ** EXP_W;
    localparam int LEG_MAX   = (LEG_PRE / 2) * (2 ** (EXP_STEPS - 1));
    localparam int LIN_MAX   = (LIN_PRE / 2) * (2 ** LIN_W);
    localparam int HALF_MAX  = (LEG_MAX > LIN_MAX) ? LEG_MAX : LIN_MAX;
    localparam int CNT_W     = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;

    logic [EXP_W-1:0] exp_q;
    logic [LIN_W-1:0] lin_q;
    path_e            path_q;
    logic [CNT_W-1:0] term;
    logic             run;

    assign run = enable & xfer_active;

    spiclk_cfg_hold #(
        .CTRL_W(CTRL_W), .EXP_W(EXP_W), .LIN_W(LIN_W),
        .EXP_LSB(16), .LIN_LSB(16), .SEL_BIT(24)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .main_ctrl(main_ctrl), .enh_ctrl(enh_ctrl),
        .exp_q(exp_q), .lin_q(lin_q), .path_q(path_q)
    );

    spiclk_term_calc #(
        .EXP_W(EXP_W), .LIN_W(LIN_W), .LEG_PRE(LEG_PRE),
        .LIN_PRE(LIN_PRE), .CNT_W(CNT_W)
    ) u_term (
        .exp_q(exp_q), .lin_q(lin_q), .path_q(path_q), .term(term)
    );

    spiclk_edge_gen #(
        .CNT_W(CNT_W)
    ) u_edge (
        .clk(clk), .rst_n(rst_n), .run(run), .idle_lvl(cpol),
        .term(term), .sclk(sclk), .tick(sclk_tick)
    );
endmodule

// File: tb/spi_sclk_gen_test.sv
`timescale 1ns/1ps
module spi_sclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        xfer_active = 1'b0;
    logic        cpol = 1'b1;
    logic [31:0] main_ctrl = '0;
    logic [31:0] enh_ctrl = '0;
    logic        sclk;
    logic        sclk_tick;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    spi_sclk_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_active(xfer_active),
        .cpol(cpol), .main_ctrl(main_ctrl), .enh_ctrl(enh_ctrl),
        .sclk(sclk), .sclk_tick(sclk_tick)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Period in source cycles, from the R1/R2 formulas
    function automatic int period_of(input logic [31:0] mc, input logic [31:0] ec);
        if (ec[24]) return 2 * (int'(ec[23:16]) + 1);
        return 4 * (1 << mc[18:16]);
    endfunction

    // Run one transfer and measure five level changes
    task automatic run_case(input logic [31:0] mc, input logic [31:0] ec,
                            input logic pol, input bit mid_change,
                            input logic [31:0] mc2, input logic [31:0] ec2,
                            input string req);
        int h = period_of(mc, ec) / 2;
        int toggles = 0;
        int last = 0;
        logic prev;
        @(negedge clk);
        main_ctrl = mc; enh_ctrl = ec; cpol = pol; enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sclk == pol, "R5", "idle level before start", int'(sclk), int'(pol));
        prev = sclk;
        xfer_active = 1'b1;
        for (int k = 1; k <= 6 * h + 4 && toggles < 5; k++) begin
            @(negedge clk);
            if (sclk != prev) begin
                toggles++;
                if (toggles == 1)
                    check(k - last == h, "R5", "first toggle delay", k - last, h);
                else
                    check(k - last == h, req, "half-period (R3 duty)", k - last, h);
                check(sclk_tick == 1'b1, "R8", "tick on toggle", int'(sclk_tick), 1);
                last = k;
                prev = sclk;
                if (mid_change && toggles == 1) begin
                    main_ctrl = mc2; enh_ctrl = ec2;
                end
            end else begin
                check(sclk_tick == 1'b0, "R8", "tick without toggle", int'(sclk_tick), 0);
            end
        end
        check(toggles == 5, req, "toggle count", toggles, 5);
        xfer_active = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sclk == pol, "R5", "idle level after stop", int'(sclk), int'(pol));
        check(sclk_tick == 1'b0, "R5", "no tick when idle", int'(sclk_tick), 0);
    endtask

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        // R4: reset state with idle polarity 1 requested
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R4", "sclk in reset", int'(sclk), 0);
        check(sclk_tick == 1'b0, "R4", "tick in reset", int'(sclk_tick), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R5", "idle after reset", int'(sclk), 1);

        // R5: enable low during a transfer keeps SCLK parked
        cpol = 1'b0; xfer_active = 1'b1; enable = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(sclk == 1'b0 && sclk_tick == 1'b0, "R5", "disabled parked",
                  int'({sclk, sclk_tick}), 0);
        end
        xfer_active = 1'b0;

        // R1: boundary exponents
        run_case(32'h0000_0000, 32'h0, 1'b0, 1'b0, '0, '0, "R1");
        run_case(32'h0007_0000, 32'h0, 1'b1, 1'b0, '0, '0, "R1");
        run_case(32'h0003_0000, 32'h0, 1'b0, 1'b0, '0, '0, "R1");
        // R2: boundary linear counts
        run_case(32'h0, 32'h0100_0000, 1'b0, 1'b0, '0, '0, "R2");
        run_case(32'h0, 32'h01FF_0000, 1'b1, 1'b0, '0, '0, "R2");
        run_case(32'h0, 32'h0104_0000, 1'b0, 1'b0, '0, '0, "R2");
        // R7: unrelated bits set on both words
        run_case(32'hFFF8_FFFF | 32'h0001_0000, 32'hFE00_FFFF | 32'h0103_0000,
                 1'b1, 1'b0, '0, '0, "R7");
        run_case(32'hA5A2_5A5A, 32'hFEFF_FFFF, 1'b0, 1'b0, '0, '0, "R7");
        // R6: change path and divider mid-transfer, then use the new setting
        run_case(32'h0002_0000, 32'h0, 1'b0, 1'b1, 32'h0, 32'h0109_0000, "R6");
        run_case(32'h0, 32'h0109_0000, 1'b0, 1'b0, '0, '0, "R6");
        run_case(32'h0, 32'h0101_0000, 1'b1, 1'b1, 32'h0005_0000, 32'h0, "R6");
        run_case(32'h0005_0000, 32'h0, 1'b1, 1'b0, '0, '0, "R6");
        // Random settings with random unrelated bits
        for (int i = 0; i < 16; i++) begin
            logic [31:0] mc = $urandom;
            logic [31:0] ec = $urandom;
            logic        pol = 1'($urandom);
            run_case(mc, ec, pol, 1'b0, '0, '0, ec[24] ? "R2" : "R1");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule